// File: doc/BRIEF.md
# Low-Power ADC Scan Sequencer

This block runs an external multi-channel ADC from an always-on clock. When enabled it powers the converter up, waits a programmed settle time and then selects each channel in ascending order. It holds each select until the converter returns a data-valid pulse and captures the sample in that cycle. After the last channel it evaluates a per-round filter-match flag from outside logic. In low-power operation it then powers the converter down for a programmed sleep interval before the next round. In normal-power operation it rescans at once.

Two match counters set the scan rate. In the low-power tier, a run of matching rounds as long as the low-power threshold promotes the block to back-to-back scanning. In the normal-power tier, a run of matching rounds as long as the normal-power threshold raises an interrupt pulse and a wakeup pulse, and both counters then clear. A mismatch in the normal-power tier drops the block back to sleeping scans. A one-shot mode scans once, pulses a completion flag and parks. A synchronous FSM-reset input clears the state machine, both timers and both counters, as the asynchronous reset does.

Top module: `lp_adc_seq`

## Requirements
- R1: At most one bit of `adc_sel_o` is high in any cycle, and no bit is ever unknown.
- R2: A round selects channel 0 and then channel 1. Each select holds until `adc_valid_i`, and `adc_data_i` is captured in that cycle into `data_o[k*DATA_W +: DATA_W]` for channel k.
- R3: After `adc_pd_o` falls, the first select rises exactly `pwrup_time_i`+1 cycles later.
- R4: In a low-power sleep between rounds, `adc_pd_o` stays high for exactly `wakeup_time_i`+1 cycles, and this length is the same in every round.
- R5: In the low-power tier a matching round increments the low-power counter and a mismatch clears it. The round that brings it to `lp_thresh_i` skips the sleep and enters the normal-power tier.
- R6: In the normal-power tier a matching round increments the normal-power counter. The round that brings it to `np_thresh_i` pulses `intr_o` and `wakeup_o` for one cycle, together with `round_done_o`, and clears both counters. A mismatch clears both counters and returns to the low-power tier.
- R7: A high `fsm_rst_i` returns the FSM to idle and zeroes the power-up timer, the wakeup timer and both match counters on the next clock.
- R8: With `enable_i` low, every select is low and `adc_pd_o` is high in the same cycle, and the FSM is idle after the next clock. Re-enabling restarts from power-up.
- R9: With `oneshot_i` high, the block scans both channels once with no sleep, pulses `oneshot_done_o` once and keeps the ADC powered down until `enable_i` falls.
- R10: With `lp_mode_i` low, rounds follow each other with no power-down, and only the normal-power counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | always-on clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| enable_i | input | 1 | sequencer enable |
| fsm_rst_i | input | 1 | synchronous clear of FSM, timers and counters |
| lp_mode_i | input | 1 | allow low-power sleeping between rounds |
| oneshot_i | input | 1 | single-round mode |
| pwrup_time_i | input | PWR_W | settle time after power-up, minus one |
| wakeup_time_i | input | WAKE_W | sleep time between low-power rounds, minus one |
| lp_thresh_i | input | CNT_W | matches needed to promote to normal power |
| np_thresh_i | input | CNT_W | matches needed to raise interrupt and wakeup |
| match_i | input | 1 | filter-match result for the round just scanned |
| adc_valid_i | input | 1 | ADC data-valid pulse |
| adc_data_i | input | DATA_W | ADC conversion result |
| adc_sel_o | output | NCH | channel selects |
| adc_pd_o | output | 1 | ADC power-down |
| data_o | output | NCH*DATA_W | last captured sample per channel |
| round_done_o | output | 1 | one-cycle pulse after each evaluated round |
| intr_o | output | 1 | interrupt pulse |
| wakeup_o | output | 1 | wakeup pulse |
| oneshot_done_o | output | 1 | one-shot completion pulse |

## Verification
The hardest state to reach is a tier change in the middle of a run. Promotion, a mismatch after promotion and a counter clear by FSM-reset each depend on the match history of several earlier rounds. The stimulus uses an ADC model that answers every select after a fixed delay. The model drives the match flag from a per-round bit pattern, so one table row replays a chosen history through promotion, interrupt and demotion. A bench reference computes the interrupt and sleep counts that the pattern should give. The FSM-reset case is placed between a first matching round and a second one. With the threshold at two, the second round sleeps only if the counter was really cleared.

// File: rtl/lp_adc_pkg.sv
package lp_adc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PWRUP = 3'd1,
    ST_SCAN  = 3'd2,
    ST_EVAL  = 3'd3,
    ST_SLEEP = 3'd4,
    ST_HOLD  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/lp_adc_timer.sv
module lp_adc_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = run_i && (cnt_q == limit_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (run_i && !hit_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lp_adc_capture.sv
module lp_adc_capture #(
  parameter int NCH    = 2,
  parameter int DATA_W = 10,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cap_i,
  input  logic [CH_W-1:0]       ch_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic [NCH*DATA_W-1:0] data_o
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [DATA_W-1:0] smp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          smp_q <= '0;
      else if (cap_i && ch_i == CH_W'(k))   smp_q <= data_i;
    end
    assign data_o[k*DATA_W +: DATA_W] = smp_q;
  end
endmodule

// File: rtl/lp_adc_match_ctr.sv
module lp_adc_match_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             eval_i,
  input  logic             match_i,
  input  logic             lp_mode_i,
  input  logic [CNT_W-1:0] lp_thresh_i,
  input  logic [CNT_W-1:0] np_thresh_i,
  output logic             fire_o,
  output logic             np_next_o,
  output logic [CNT_W-1:0] lp_cnt_o,
  output logic [CNT_W-1:0] np_cnt_o
);
  logic [CNT_W-1:0] lp_q, np_q, lp_d, np_d;
  logic             act_q, act_d;
  logic             np_tier;
  logic [CNT_W:0]   lp_inc, np_inc;

  assign np_tier = act_q || !lp_mode_i;
  assign lp_inc  = {1'b0, lp_q} + 1'b1;
  assign np_inc  = {1'b0, np_q} + 1'b1;

  always_comb begin
    lp_d   = lp_q;
    np_d   = np_q;
    act_d  = act_q;
    fire_o = 1'b0;
    if (eval_i) begin
      if (np_tier) begin
        if (match_i) begin
          if (np_inc >= {1'b0, np_thresh_i}) begin
            fire_o = 1'b1;
            np_d   = '0;
            lp_d   = '0;
            act_d  = 1'b0;
          end else begin
            np_d = np_inc[CNT_W-1:0];
          end
        end else begin
          np_d  = '0;
          lp_d  = '0;
          act_d = 1'b0;
        end
      end else if (match_i) begin
        if (lp_inc >= {1'b0, lp_thresh_i}) begin
          lp_d  = '0;
          act_d = 1'b1;  // promote: next round without sleep
        end else begin
          lp_d = lp_inc[CNT_W-1:0];
        end
      end else begin
        lp_d = '0;
      end
    end
  end

  assign np_next_o = act_d;
  assign lp_cnt_o  = lp_q;
  assign np_cnt_o  = np_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q  <= '0;
      np_q  <= '0;
      act_q <= 1'b0;
    end else if (clr_i) begin
      lp_q  <= '0;
      np_q  <= '0;
      act_q <= 1'b0;
    end else begin
      lp_q  <= lp_d;
      np_q  <= np_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/lp_adc_seq.sv
module lp_adc_seq
  import lp_adc_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DATA_W = 10,
  parameter int PWR_W  = 8,
  parameter int WAKE_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  enable_i,
  input  logic                  fsm_rst_i,
  input  logic                  lp_mode_i,
  input  logic                  oneshot_i,
  input  logic [PWR_W-1:0]      pwrup_time_i,
  input  logic [WAKE_W-1:0]     wakeup_time_i,
  input  logic [CNT_W-1:0]      lp_thresh_i,
  input  logic [CNT_W-1:0]      np_thresh_i,
  input  logic                  match_i,
  input  logic                  adc_valid_i,
  input  logic [DATA_W-1:0]     adc_data_i,
  output logic [NCH-1:0]        adc_sel_o,
  output logic                  adc_pd_o,
  output logic [NCH*DATA_W-1:0] data_o,
  output logic                  round_done_o,
  output logic                  intr_o,
  output logic                  wakeup_o,
  output logic                  oneshot_done_o
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

  seq_state_e        state_q, state_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic              pwr_hit, wake_hit;
  logic [PWR_W-1:0]  pwr_cnt;
  logic [WAKE_W-1:0] wake_cnt;
  logic [CNT_W-1:0]  lp_cnt, np_cnt;
  logic              in_eval, eval_cnt, fire, np_next, cap;
  logic              rdone_q, intr_q, done_q;

  lp_adc_timer #(.W(PWR_W)) u_pwr_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fsm_rst_i || state_q != ST_PWRUP),
    .run_i   (state_q == ST_PWRUP),
    .limit_i (pwrup_time_i),
    .cnt_o   (pwr_cnt),
    .hit_o   (pwr_hit)
  );

  lp_adc_timer #(.W(WAKE_W)) u_wake_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fsm_rst_i || state_q != ST_SLEEP),
    .run_i   (state_q == ST_SLEEP),
    .limit_i (wakeup_time_i),
    .cnt_o   (wake_cnt),
    .hit_o   (wake_hit)
  );

  assign in_eval  = enable_i && state_q == ST_EVAL;
  assign eval_cnt = in_eval && !oneshot_i;

  lp_adc_match_ctr #(.CNT_W(CNT_W)) u_match (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (fsm_rst_i),
    .eval_i      (eval_cnt),
    .match_i     (match_i),
    .lp_mode_i   (lp_mode_i),
    .lp_thresh_i (lp_thresh_i),
    .np_thresh_i (np_thresh_i),
    .fire_o      (fire),
    .np_next_o   (np_next),
    .lp_cnt_o    (lp_cnt),
    .np_cnt_o    (np_cnt)
  );

  assign cap = enable_i && state_q == ST_SCAN && adc_valid_i;

  lp_adc_capture #(.NCH(NCH), .DATA_W(DATA_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .ch_i   (ch_q),
    .data_i (adc_data_i),
    .data_o (data_o)
  );

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    unique case (state_q)
      ST_IDLE:  if (enable_i) state_d = ST_PWRUP;
      ST_PWRUP: if (pwr_hit) begin
        state_d = ST_SCAN;
        ch_d    = '0;
      end
      ST_SCAN:  if (adc_valid_i) begin
        if (ch_q == LAST_CH) state_d = ST_EVAL;
        else                 ch_d    = ch_q + 1'b1;
      end
      ST_EVAL: begin
        ch_d = '0;
        if (oneshot_i)                  state_d = ST_HOLD;
        else if (lp_mode_i && !np_next) state_d = ST_SLEEP;
        else                            state_d = ST_SCAN;
      end
      ST_SLEEP: if (wake_hit) state_d = ST_PWRUP;
      ST_HOLD:  state_d = ST_HOLD;
      default:  state_d = ST_IDLE;
    endcase
    if (!enable_i) begin
      state_d = ST_IDLE;
      ch_d    = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
    end else if (fsm_rst_i) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdone_q <= 1'b0;
      intr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (fsm_rst_i) begin
      rdone_q <= 1'b0;
      intr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      rdone_q <= in_eval;
      intr_q  <= eval_cnt && fire;
      done_q  <= in_eval && oneshot_i;
    end
  end

  // selects gated by enable so a disable drops them in the same cycle
  for (genvar k = 0; k < NCH; k++) begin : g_sel
    assign adc_sel_o[k] = enable_i && state_q == ST_SCAN && ch_q == CH_W'(k);
  end

  assign adc_pd_o       = !enable_i || state_q == ST_IDLE || state_q == ST_SLEEP ||
                          state_q == ST_HOLD;
  assign round_done_o   = rdone_q;
  assign intr_o         = intr_q;
  assign wakeup_o       = intr_q;
  assign oneshot_done_o = done_q;
endmodule

// File: rtl/lp_adc_seq_chk.sv
module lp_adc_seq_chk
  import lp_adc_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int PWR_W  = 8,
  parameter int WAKE_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              fsm_rst_i,
  input logic [PWR_W-1:0]  pwrup_time_i,
  input logic [WAKE_W-1:0] wakeup_time_i,
  input logic [NCH-1:0]    adc_sel_o,
  input logic              adc_pd_o,
  input logic              round_done_o,
  input logic              intr_o,
  input logic              wakeup_o,
  input logic              oneshot_done_o,
  input seq_state_e        state_q,
  input logic [PWR_W-1:0]  pwr_cnt,
  input logic [WAKE_W-1:0] wake_cnt,
  input logic [CNT_W-1:0]  lp_cnt,
  input logic [CNT_W-1:0]  np_cnt
);
  assert_sel_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(adc_sel_o) && !$isunknown(adc_sel_o));

  assert_settle_time_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && $past(state_q) == ST_PWRUP) |->
      $past(pwr_cnt) == $past(pwrup_time_i));

  assert_sleep_pd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP) |-> adc_pd_o);

  assert_sleep_time_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PWRUP && $past(state_q) == ST_SLEEP) |->
      $past(wake_cnt) == $past(wakeup_time_i));

  assert_intr_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |-> wakeup_o && round_done_o);

  assert_intr_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |=> !intr_o);

  assert_fsm_rst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fsm_rst_i) |-> state_q == ST_IDLE && pwr_cnt == '0 && wake_cnt == '0 &&
      lp_cnt == '0 && np_cnt == '0);

  assert_disable_out_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> adc_sel_o == '0 && adc_pd_o);

  assert_disable_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!enable_i) |-> state_q == ST_IDLE);

  assert_oneshot_park_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oneshot_done_o |-> state_q == ST_HOLD && adc_pd_o);
endmodule

bind lp_adc_seq lp_adc_seq_chk #(
  .NCH(NCH), .PWR_W(PWR_W), .WAKE_W(WAKE_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .enable_i       (enable_i),
  .fsm_rst_i      (fsm_rst_i),
  .pwrup_time_i   (pwrup_time_i),
  .wakeup_time_i  (wakeup_time_i),
  .adc_sel_o      (adc_sel_o),
  .adc_pd_o       (adc_pd_o),
  .round_done_o   (round_done_o),
  .intr_o         (intr_o),
  .wakeup_o       (wakeup_o),
  .oneshot_done_o (oneshot_done_o),
  .state_q        (state_q),
  .pwr_cnt        (pwr_cnt),
  .wake_cnt       (wake_cnt),
  .lp_cnt         (lp_cnt),
  .np_cnt         (np_cnt)
);

// File: tb/test_lp_adc_seq.sv
`timescale 1ns/1ps
module test_lp_adc_seq;
  localparam int PWR = 3;
  localparam int WK  = 5;

  typedef struct packed {
    logic       lp;
    logic [7:0] lpth;
    logic [7:0] npth;
    logic [7:0] pat;   // bit r = match flag of round r
    logic [3:0] n;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 8'd2, 8'd2, 8'b1111_1111, 4'd8},
    '{1'b1, 8'd1, 8'd3, 8'b1101_1011, 4'd8},
    '{1'b0, 8'd1, 8'd3, 8'b1111_0111, 4'd8},
    '{1'b1, 8'd1, 8'd3, 8'b1111_1011, 4'd8},
    '{1'b1, 8'd2, 8'd2, 8'b0000_0000, 4'd4},
    '{1'b0, 8'd1, 8'd1, 8'b1111_1111, 4'd5}
  };

  logic clk = 0, rst_n = 0, enable = 0, fsm_rst = 0, lp_mode = 0, oneshot = 0;
  logic [7:0]  pwrup_time = 8'(PWR);
  logic [15:0] wakeup_time = 16'(WK);
  logic [7:0]  lp_th = 0, np_th = 0;
  logic        match = 0, adc_valid = 0;
  logic [9:0]  adc_data = 0;
  logic [1:0]  sel;
  logic        pd;
  logic [19:0] data;
  logic        round_done, intr, wake, done;

  int checks = 0, fails = 0;
  int rounds, intrs, wakes, dones, sleeps, sl_min, sl_max, sl_run;
  int st_min, st_max, st_since, sel_bad, rnd, wcnt;
  bit st_armed;
  logic pd_prev = 1;
  logic [7:0] pat_cur = 0;

  always #4 clk = ~clk;

  lp_adc_seq i_lp_adc_seq (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .fsm_rst_i(fsm_rst),
    .lp_mode_i(lp_mode), .oneshot_i(oneshot), .pwrup_time_i(pwrup_time),
    .wakeup_time_i(wakeup_time), .lp_thresh_i(lp_th), .np_thresh_i(np_th),
    .match_i(match), .adc_valid_i(adc_valid), .adc_data_i(adc_data),
    .adc_sel_o(sel), .adc_pd_o(pd), .data_o(data), .round_done_o(round_done),
    .intr_o(intr), .wakeup_o(wake), .oneshot_done_o(done)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    rounds = 0; intrs = 0; wakes = 0; dones = 0; sleeps = 0;
    sl_min = 1 << 30; sl_max = 0; sl_run = 0;
    st_min = 1 << 30; st_max = 0; st_armed = 0; st_since = 0; sel_bad = 0; rnd = 0;
  endtask

  // ADC model: answers each select after two idle cycles, drives match per round
  initial begin
    wcnt = 0;
    forever begin
      @(negedge clk);
      if (sel != 0 && enable) begin
        if (wcnt >= 2) begin
          adc_valid = 1;
          adc_data  = 10'(rnd * 4 + (sel[1] ? 3 : 1));
          if (sel[1]) begin
            match = pat_cur[rnd[2:0]];
            rnd++;
          end
          wcnt = 0;
        end else begin
          adc_valid = 0;
          wcnt++;
        end
      end else begin
        adc_valid = 0;
        wcnt = 0;
      end
    end
  end

  // port monitor
  initial begin
    forever begin
      @(negedge clk);
      if ($isunknown(sel) || sel == 2'b11) sel_bad++;
      if (round_done) rounds++;
      if (intr) intrs++;
      if (wake) wakes++;
      if (done) dones++;
      if (pd && !pd_prev && enable && rounds > 0) sleeps++;
      if (!enable) sl_run = 0;
      else if (pd) sl_run++;
      else begin
        if (pd_prev && sl_run > 0 && rounds > 0) begin
          if (sl_run < sl_min) sl_min = sl_run;
          if (sl_run > sl_max) sl_max = sl_run;
        end
        sl_run = 0;
      end
      if (!pd && pd_prev) begin
        st_since = 0;
        st_armed = 1;
      end else if (st_armed) st_since++;
      if (st_armed && sel != 0) begin
        if (st_since < st_min) st_min = st_since;
        if (st_since > st_max) st_max = st_since;
        st_armed = 0;
      end
      pd_prev = pd;
    end
  end

  function automatic void ref_model(input bit lp, input int lpth, input int npth,
                                    input logic [7:0] pat, input int n,
                                    output int ni, output int ns);
    int lpc = 0, npc = 0;
    bit tier = 0;
    ni = 0; ns = 0;
    for (int r = 0; r < n; r++) begin
      bit m;
      m = pat[r];
      if (!lp || tier) begin
        if (m) begin
          npc++;
          if (npc >= npth) begin
            ni++; npc = 0; lpc = 0;
            if (lp) begin tier = 0; ns++; end
          end
        end else begin
          npc = 0; lpc = 0;
          if (lp) begin tier = 0; ns++; end
        end
      end else if (m) begin
        lpc++;
        if (lpc >= lpth) begin lpc = 0; tier = 1; end
        else ns++;
      end else begin
        lpc = 0; ns++;
      end
    end
  endfunction

  task automatic wait_rounds(int n);
    while (rounds < n) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic setup(bit lp, int lpth, int npth, logic [7:0] pat, bit one);
    @(negedge clk); #1;
    enable = 0; lp_mode = lp; lp_th = 8'(lpth); np_th = 8'(npth);
    pat_cur = pat; oneshot = one;
    repeat (2) @(negedge clk);
    #1;
    clear_stats();
    enable = 1;
  endtask

  task automatic run_vec(vec_t v);
    int ei, es;
    ref_model(v.lp, int'(v.lpth), int'(v.npth), v.pat, int'(v.n), ei, es);
    setup(v.lp, int'(v.lpth), int'(v.npth), v.pat, 0);
    wait_rounds(int'(v.n));
    enable = 0;
    chk("R5/R6 interrupt count", intrs, ei);
    chk("R6 wakeup count", wakes, ei);
    chk(v.lp ? "R5 sleep count" : "R10 no sleep", sleeps, es);
    chk("R3 settle time", st_max, PWR + 1);
    chk("R3 settle time min", st_min, PWR + 1);
    chk("R2 ch0 data", int'(data[9:0]), (int'(v.n) - 1) * 4 + 1);
    chk("R2 ch1 data", int'(data[19:10]), (int'(v.n) - 1) * 4 + 3);
    chk("R1 select onehot", sel_bad, 0);
    if (es >= 2) begin
      chk("R4 sleep length max", sl_max, WK + 1);
      chk("R4 sleep length min", sl_min, WK + 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clear_stats();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R8 reset pd", int'(pd), 1);
    chk("R1 reset sel", int'(sel), 0);
    chk("R6 reset intr", int'(intr), 0);
    chk("R2 reset data", int'(data), 0);

    for (int i = 0; i < 6; i++) run_vec(VECS[i]);

    // R7: counter cleared between two matches, so the second round still sleeps
    setup(1, 2, 5, 8'hFF, 0);
    wait_rounds(1);
    fsm_rst = 1;
    @(negedge clk); #1;
    fsm_rst = 0;
    wait_rounds(2);
    enable = 0;
    chk("R7 sleep after fsm reset", sleeps, 2);
    chk("R7 no interrupt", intrs, 0);

    // R8: disable while a select is up
    setup(0, 1, 200, 8'hFF, 0);
    while (sel == 0) begin
      @(negedge clk); #1;
    end
    enable = 0;
    #1;
    chk("R8 sel drops at once", int'(sel), 0);
    chk("R8 pd rises at once", int'(pd), 1);
    @(negedge clk); #1;
    chk("R8 sel stays low", int'(sel), 0);
    clear_stats();
    enable = 1;
    wait_rounds(1);
    enable = 0;
    chk("R8 restart via power-up", st_max, PWR + 1);

    // R9: one-shot
    setup(1, 1, 1, 8'hFF, 1);
    repeat (80) @(negedge clk);
    #1;
    chk("R9 single round", rounds, 1);
    chk("R9 done pulse", dones, 1);
    chk("R9 parked pd", int'(pd), 1);
    chk("R9 parked sel", int'(sel), 0);
    chk("R9 no interrupt", intrs, 0);
    chk("R2 one-shot ch1 data", int'(data[19:10]), 3);
    enable = 0;
    oneshot = 0;

    // R4: longer sleep, same every round
    wakeup_time = 16'd9;
    setup(1, 2, 2, 8'h00, 0);
    wait_rounds(4);
    enable = 0;
    chk("R4 long sleep max", sl_max, 10);
    chk("R4 long sleep min", sl_min, 10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule